// File: doc/BRIEF.md
# Per-Source Edge/Level Interrupt Controller

This block gathers seven interrupt condition lines into a single interrupt request. Each line has an enable bit and a two-bit trigger code. The code selects one of three trigger types: the arrival of the condition (a rising edge), its removal (a falling edge), or its presence (a level). A fourth code turns the source off. Events that pass the enable are recorded in a status register. The interrupt request is the OR of all status bits. A separate two-bit polarity setting decides whether the request is driven active-high, driven active-low, or held low.

Software programs the enables and trigger codes through a small write port. It then reads the status register to find which sources fired. The high bit of each trigger code comes from one register and the low bit from another, both at the same bit position as the source. Reading the status register clears the bits of the edge-triggered sources. Level-triggered bits track the condition and are not cleared by a read.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: After reset the enable register, both trigger-code registers and the status register read as 0, and with polarity 00 the output `irq_o` is 0.
- R2: Address 0 is the enable register, address 1 holds the high trigger-code bits and address 2 holds the low trigger-code bits; each reads back what was written. Source n is bit n at every address, so the trigger code of source n is {high[n], low[n]}. The seven sources occupy bits 6 down to 0: PLL channel change, output slip, format-detect change, channel-status change, receiver error, Q-subcode change and frame change.
- R3: With code 00 (rising edge) and its enable bit at 1, a 0-to-1 change of a condition sets its status bit, and the bit stays set after the condition falls until the status register is read. A 1-to-0 change does not set the bit.
- R4: With code 01 (falling edge) and its enable bit at 1, a 1-to-0 change of a condition sets its status bit, which is sticky as in R3. A 0-to-1 change does not set the bit.
- R5: With code 10 (level) the status bit equals the sampled condition ANDed with its enable bit. A read of the status register does not clear it.
- R6: With code 11 the source is off and its status bit stays 0 whatever the condition does.
- R7: An enable bit of 0 keeps its source from setting its status bit in every trigger code, so that source cannot raise the interrupt.
- R8: A read of the status register (address 3) returns the current status and clears the edge-triggered bits on the following clock edge. If a new qualifying edge arrives in the same cycle as the read, its bit is left set.
- R9: Writes to address 3 have no effect on the status register.
- R10: The output `irq_o` is built from the OR of all status bits. Polarity 00 drives it active-high, polarity 01 drives it active-low, and polarity 10 or 11 holds it at 0.
- R11: A status bit, and with it `irq_o`, responds on the second rising clock edge after the condition input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 7 | Interrupt condition lines, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 enable, 1 code high, 2 code low, 3 status) |
| wr_data | input | 7 | Write data |
| rd_en | input | 1 | Register read strobe; at address 3 it clears the edge-triggered status bits |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 7 | Contents of the register at `rd_addr`, combinational |
| pol_i | input | 2 | Output polarity: 00 active-high, 01 active-low, 1x held low |
| irq_o | output | 1 | Interrupt request |

## Verification
A condition change driven between clock edges reaches the input sampling register on the first rising edge and the status register on the second. The bench therefore waits at least four edges before it reads the status, except in the latency test, which samples `irq_o` after the first edge (expecting 0) and again after the second (expecting 1). Reads are combinational. The bench samples `rd_data` while the strobe is held, before the edge that applies the clear. It then reads again to see the effect of that clear, and for the same-cycle case it starts the read in the cycle in which the sampled edge is present. Changes to polarity act on `irq_o` with no clock edge, so the bench checks them a short time after the setting changes.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned NSRC = 7;
    localparam int unsigned AW   = 2;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_LEVEL = 2'b10,
        TRIG_OFF   = 2'b11
    } trig_mode_e;

    typedef enum logic [AW-1:0] {
        ADDR_ENABLE  = 2'd0,
        ADDR_CODE_HI = 2'd1,
        ADDR_CODE_LO = 2'd2,
        ADDR_STATUS  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pkg::*;
#(
    parameter int unsigned NSRC = irq_pkg::NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [NSRC-1:0] wr_data,
    output logic [NSRC-1:0] enable_o,
    output logic [NSRC-1:0] code_hi_o,
    output logic [NSRC-1:0] code_lo_o
);
    typedef struct packed {
        logic [NSRC-1:0] enable;
        logic [NSRC-1:0] code_hi;
        logic [NSRC-1:0] code_lo;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                ADDR_ENABLE:  cfg_d.enable  = wr_data;
                ADDR_CODE_HI: cfg_d.code_hi = wr_data;
                ADDR_CODE_LO: cfg_d.code_lo = wr_data;
                default:      cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign enable_o  = cfg_q.enable;
    assign code_hi_o = cfg_q.code_hi;
    assign code_lo_o = cfg_q.code_lo;
endmodule

// File: rtl/irq_edge_sense.sv
module irq_edge_sense #(
    parameter int unsigned NSRC = irq_pkg::NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cond_i,
    output logic [NSRC-1:0] level_o,
    output logic [NSRC-1:0] rise_o,
    output logic [NSRC-1:0] fall_o
);
    typedef struct packed {
        logic [NSRC-1:0] samp;
        logic [NSRC-1:0] prev;
    } sense_t;

    sense_t sn_d, sn_q;

    always_comb begin
        sn_d.samp = cond_i;
        sn_d.prev = sn_q.samp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sn_q <= '0;
        else        sn_q <= sn_d;
    end

    assign level_o = sn_q.samp;
    assign rise_o  = sn_q.samp & ~sn_q.prev;
    assign fall_o  = ~sn_q.samp & sn_q.prev;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trig_mode_e mode_i,
    input  logic       enable_i,
    input  logic       level_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       clear_i,
    output logic       stat_o
);
    typedef struct packed {
        logic stat;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        unique case (mode_i)
            TRIG_RISE:  cell_d.stat = (cell_q.stat & ~clear_i) | (rise_i & enable_i);
            TRIG_FALL:  cell_d.stat = (cell_q.stat & ~clear_i) | (fall_i & enable_i);
            TRIG_LEVEL: cell_d.stat = level_i & enable_i;
            default:    cell_d.stat = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign stat_o = cell_q.stat;
endmodule

// File: rtl/irq_trigger_ctrl.sv
module irq_trigger_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned NSRC = irq_pkg::NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cond_i,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [NSRC-1:0] wr_data,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    output logic [NSRC-1:0] rd_data,
    input  logic [1:0]      pol_i,
    output logic            irq_o
);
    logic [NSRC-1:0] enable_q;
    logic [NSRC-1:0] code_hi_q;
    logic [NSRC-1:0] code_lo_q;
    logic [NSRC-1:0] level_s;
    logic [NSRC-1:0] rise_s;
    logic [NSRC-1:0] fall_s;
    logic [NSRC-1:0] stat_q;
    logic            stat_clear;
    logic            irq_any;

    irq_cfg_regs #(.NSRC(NSRC)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .enable_o  (enable_q),
        .code_hi_o (code_hi_q),
        .code_lo_o (code_lo_q)
    );

    irq_edge_sense #(.NSRC(NSRC)) u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond_i  (cond_i),
        .level_o (level_s),
        .rise_o  (rise_s),
        .fall_o  (fall_s)
    );

    assign stat_clear = rd_en && (reg_addr_e'(rd_addr) == ADDR_STATUS);

    for (genvar n = 0; n < NSRC; n++) begin : g_src
        irq_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_i   (trig_mode_e'({code_hi_q[n], code_lo_q[n]})),
            .enable_i (enable_q[n]),
            .level_i  (level_s[n]),
            .rise_i   (rise_s[n]),
            .fall_i   (fall_s[n]),
            .clear_i  (stat_clear),
            .stat_o   (stat_q[n])
        );
    end

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            ADDR_ENABLE:  rd_data = enable_q;
            ADDR_CODE_HI: rd_data = code_hi_q;
            ADDR_CODE_LO: rd_data = code_lo_q;
            default:      rd_data = stat_q;
        endcase
    end

    assign irq_any = |stat_q;

    always_comb begin
        unique case (pol_i)
            2'b00:   irq_o = irq_any;
            2'b01:   irq_o = ~irq_any;
            default: irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_trigger_ctrl_chk.sv
module irq_trigger_ctrl_chk #(
    parameter int unsigned NSRC = irq_pkg::NSRC
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] enable_q,
    input logic [NSRC-1:0] code_hi_q,
    input logic [NSRC-1:0] code_lo_q,
    input logic [NSRC-1:0] level_s,
    input logic [NSRC-1:0] rise_s,
    input logic [NSRC-1:0] stat_q,
    input logic            rd_en,
    input logic [1:0]      rd_addr,
    input logic [1:0]      pol_i,
    input logic            irq_o
);
    logic rd_status;
    assign rd_status = rd_en && (rd_addr == 2'd3);

    for (genvar n = 0; n < NSRC; n++) begin : g_bit
        // R6
        reserved_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code_hi_q[n] && code_lo_q[n]) |=> !stat_q[n]);

        // R5
        level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code_hi_q[n] && !code_lo_q[n]) |=> (stat_q[n] == $past(level_s[n] && enable_q[n])));

        // R7
        masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!enable_q[n] && !stat_q[n]) |=> !stat_q[n]);

        // R8
        edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!code_hi_q[n] && stat_q[n] && !rd_status) |=> stat_q[n]);

        // R8
        read_keeps_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!code_hi_q[n] && !code_lo_q[n] && enable_q[n] && rise_s[n] && rd_status) |=> stat_q[n]);
    end

    // R10
    pol_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_i == 2'b01) |-> (irq_o == (stat_q == '0)));

    // R10
    pol_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pol_i[1] |-> !irq_o);
endmodule

bind irq_trigger_ctrl irq_trigger_ctrl_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_q  (enable_q),
    .code_hi_q (code_hi_q),
    .code_lo_q (code_lo_q),
    .level_s   (level_s),
    .rise_s    (rise_s),
    .stat_q    (stat_q),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .pol_i     (pol_i),
    .irq_o     (irq_o)
);

// File: tb/irq_trigger_ctrl_tb.sv
`timescale 1ns/1ps
module irq_trigger_ctrl_tb;
    localparam int NS = 7;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] cond_i = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [NS-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_addr = '0;
    logic [NS-1:0] rd_data;
    logic [1:0]    pol_i = 2'b00;
    logic          irq_o;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_trigger_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pol_i(pol_i), .irq_o(irq_o)
    );

    // {source[2:0], enable, code[1:0], cond_before, cond_after, expected_status[6:0]}
    localparam logic [14:0] VEC [NV] = '{
        {3'd0, 1'b1, 2'b00, 1'b0, 1'b1, 7'h01},
        {3'd1, 1'b1, 2'b00, 1'b1, 1'b0, 7'h00},
        {3'd2, 1'b1, 2'b01, 1'b1, 1'b0, 7'h04},
        {3'd3, 1'b1, 2'b01, 1'b0, 1'b1, 7'h00},
        {3'd4, 1'b1, 2'b10, 1'b0, 1'b1, 7'h10},
        {3'd5, 1'b1, 2'b10, 1'b1, 1'b0, 7'h00},
        {3'd6, 1'b1, 2'b11, 1'b0, 1'b1, 7'h00},
        {3'd6, 1'b1, 2'b11, 1'b1, 1'b0, 7'h00},
        {3'd5, 1'b0, 2'b00, 1'b0, 1'b1, 7'h00},
        {3'd6, 1'b1, 2'b00, 1'b0, 1'b1, 7'h40},
        {3'd2, 1'b0, 2'b10, 1'b0, 1'b1, 7'h00}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [NS-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [NS-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_cond(input logic [NS-1:0] v);
        @(negedge clk);
        cond_i = v;
    endtask

    task automatic configure(input logic [NS-1:0] en, input logic [NS-1:0] hi, input logic [NS-1:0] lo);
        logic [NS-1:0] junk;
        reg_write(2'd0, en);
        reg_write(2'd1, hi);
        reg_write(2'd2, lo);
        wait_cycles(3);
        reg_read(2'd3, junk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL R11: watchdog actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [NS-1:0] rv;
        logic [NS-1:0] bitv;
        string tag;

        // R1 reset state
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);
        #1 check("R1 irq after reset", {7'd0, irq_o}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            reg_read(a[1:0], rv);
            check("R1 register reset", {1'b0, rv}, 8'h00);
        end

        // R2 readback
        reg_write(2'd0, 7'h55);
        reg_write(2'd1, 7'h2A);
        reg_write(2'd2, 7'h33);
        reg_read(2'd0, rv); check("R2 enable readback", {1'b0, rv}, 8'h55);
        reg_read(2'd1, rv); check("R2 code high readback", {1'b0, rv}, 8'h2A);
        reg_read(2'd2, rv); check("R2 code low readback", {1'b0, rv}, 8'h33);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            bitv = 7'(1) << VEC[i][14:12];
            if (!VEC[i][11])               tag = "R7 vector";
            else if (VEC[i][10:9] == 2'b00) tag = "R3 vector";
            else if (VEC[i][10:9] == 2'b01) tag = "R4 vector";
            else if (VEC[i][10:9] == 2'b10) tag = "R5 vector";
            else                            tag = "R6 vector";
            set_cond('0);
            wait_cycles(3);
            configure(VEC[i][11] ? bitv : 7'h00,
                      VEC[i][10] ? bitv : 7'h00,
                      VEC[i][9]  ? bitv : 7'h00);
            set_cond(VEC[i][8] ? bitv : 7'h00);
            wait_cycles(4);
            reg_read(2'd3, rv);
            set_cond(VEC[i][7] ? bitv : 7'h00);
            wait_cycles(4);
            #1 check({tag, " irq"}, {7'd0, irq_o}, {7'd0, |VEC[i][6:0]});
            reg_read(2'd3, rv);
            check(tag, {1'b0, rv}, {1'b0, VEC[i][6:0]});
        end

        // R9 status write ignored
        set_cond('0);
        configure(7'h00, 7'h00, 7'h00);
        reg_write(2'd3, 7'h7F);
        reg_read(2'd3, rv);
        check("R9 status write ignored", {1'b0, rv}, 8'h00);

        // R3 sticky then cleared by read (R8)
        configure(7'h08, 7'h00, 7'h00);
        set_cond(7'h08); wait_cycles(4);
        set_cond(7'h00); wait_cycles(4);
        reg_read(2'd3, rv); check("R3 sticky after condition fell", {1'b0, rv}, 8'h08);
        reg_read(2'd3, rv); check("R8 cleared by read", {1'b0, rv}, 8'h00);

        // R5 level not cleared by read, then follows condition down
        configure(7'h10, 7'h10, 7'h00);
        set_cond(7'h10); wait_cycles(4);
        reg_read(2'd3, rv); check("R5 level set", {1'b0, rv}, 8'h10);
        reg_read(2'd3, rv); check("R5 level survives read", {1'b0, rv}, 8'h10);
        set_cond(7'h00); wait_cycles(3);
        reg_read(2'd3, rv); check("R5 level follows down", {1'b0, rv}, 8'h00);

        // R11 latency of irq_o
        configure(7'h02, 7'h00, 7'h00);
        set_cond(7'h02);
        @(negedge clk); #1 check("R11 irq after one edge", {7'd0, irq_o}, 8'h00);
        @(negedge clk); #1 check("R11 irq after two edges", {7'd0, irq_o}, 8'h01);

        // R10 polarity with status set
        pol_i = 2'b01; #1 check("R10 active-low asserted", {7'd0, irq_o}, 8'h00);
        pol_i = 2'b10; #1 check("R10 held low 10", {7'd0, irq_o}, 8'h00);
        pol_i = 2'b11; #1 check("R10 held low 11", {7'd0, irq_o}, 8'h00);
        pol_i = 2'b00;
        reg_read(2'd3, rv);
        #1 check("R10 active-high idle", {7'd0, irq_o}, 8'h00);
        pol_i = 2'b01; #1 check("R10 active-low idle", {7'd0, irq_o}, 8'h01);
        pol_i = 2'b00;

        // R8 edge in the same cycle as a status read stays set
        set_cond('0);
        configure(7'h01, 7'h00, 7'h00);
        set_cond(7'h01);
        reg_read(2'd3, rv); check("R8 read during edge returns old", {1'b0, rv}, 8'h00);
        reg_read(2'd3, rv); check("R8 edge kept over read", {1'b0, rv}, 8'h01);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule